// File: doc/BRIEF.md
# Pointer-Chasing Prefetch Engine

This block turns a compact traversal recipe into a chain of dependent memory prefetches. Recipes are installed ahead of time into a small table. Each recipe is keyed by the program counter of the load that begins a linked-structure walk. A recipe holds up to four steps and a repeat count. Each step is a signed immediate offset paired with a history distance.

When a retired load's PC matches a stored recipe, the value that load returned becomes the root of a walk. The engine then runs through the steps in order, once for each repetition. For each step it picks a base from a history of recently returned values, adds the offset, and issues one prefetch request. It then pushes the response onto the history. The next address therefore depends on data fetched just before, not on a stride. Because of this, the engine keeps only one request in flight at a time.

A walk ends after the last step of the last repetition. It also ends as soon as the selected base is zero, which is treated as a null pointer. While a walk runs, further retired-load hits are dropped.

Top module: `lsp_prefetch_top`

## Requirements
- R1: After reset, busy and req_valid are low and the recipe table is empty, so no retired load starts a walk.
- R2: A pulse on inst_valid writes slot inst_slot with tag inst_pc. A later ret_valid whose ret_pc equals a valid tag, and whose ret_value is nonzero, starts a walk whose first base is ret_value. A ret_pc that matches no valid tag starts nothing.
- R3: Step i uses offset bits inst_offs[16*i+15:16*i], which are sign-extended, and distance field inst_backs[2*i+1:2*i]. A field value k selects the value returned k+1 accesses earlier, with the initiating load counting as the first access. The request address is that value plus the offset.
- R4: Steps 0 through inst_nsteps-1 (values above 4 act as 4) are issued in order, and the whole list is repeated inst_reps times. After the final response, busy falls and no further request appears.
- R5: After a request is accepted (req_valid and req_ready both high at a clock edge), req_valid stays low until rsp_valid delivers the response.
- R6: While req_valid is high and req_ready is low, req_valid stays high and req_addr stays unchanged.
- R7: A selected base of zero ends the walk without issuing a request. A matching retired load whose value is zero starts no walk.
- R8: A retired-load hit that arrives while busy is high is ignored, and the walk in progress carries on unchanged.
- R9: Installing into an occupied slot replaces its recipe and its tag. An install with inst_nsteps or inst_reps equal to zero leaves that slot invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inst_valid | input | 1 | Install strobe |
| inst_slot | input | 3 | Table slot to write |
| inst_pc | input | 32 | Tag: PC of the initiating load |
| inst_nsteps | input | 3 | Number of steps (0 invalidates) |
| inst_reps | input | 8 | Repeat count (0 invalidates) |
| inst_offs | input | 64 | Four packed 16-bit signed offsets, step 0 in the low bits |
| inst_backs | input | 8 | Four packed 2-bit history distances minus one, step 0 in the low bits |
| ret_valid | input | 1 | A load has retired |
| ret_pc | input | 32 | PC of the retired load |
| ret_value | input | 32 | Value the retired load returned |
| req_valid | output | 1 | Prefetch request valid |
| req_addr | output | 32 | Prefetch address |
| req_ready | input | 1 | Memory accepts the request |
| rsp_valid | input | 1 | Prefetch response valid |
| rsp_data | input | 32 | Prefetch response data |
| busy | output | 1 | A walk is in progress |

## Verification
A corrupted history entry or a wrong step or repeat counter shows up at req_addr on the next request. Because every address is built from earlier responses, one such error changes every address that follows in the chain. A wrong state transition appears either as a second request issued before a response arrives, or as busy staying high or falling too early, and it shows within one cycle of the response concerned. Table faults show only on the next retired load that matches the slot, as a walk that starts when it should not or fails to start when it should.

// File: rtl/lsp_pkg.sv
package lsp_pkg;
    localparam int PC_W       = 32;
    localparam int VAL_W      = 32;
    localparam int OFF_W      = 16;
    localparam int BACK_W     = 2;
    localparam int HIST_DEPTH = 1 << BACK_W;
    localparam int MAX_STEPS  = 4;
    localparam int STEP_W     = $clog2(MAX_STEPS);
    localparam int CNT_W      = $clog2(MAX_STEPS + 1);
    localparam int REP_W      = 8;
    localparam int SLOTS      = 8;
    localparam int SLOT_W     = $clog2(SLOTS);

    typedef struct packed {
        logic [OFF_W-1:0]  off;
        logic [BACK_W-1:0] back;
    } step_t;

    typedef struct packed {
        logic [CNT_W-1:0]            nsteps;
        logic [REP_W-1:0]            reps;
        step_t [MAX_STEPS-1:0]       steps;
    } recipe_t;

    typedef struct packed {
        logic            valid;
        logic [PC_W-1:0] tag;
        recipe_t         body;
    } slot_t;

    typedef enum logic [1:0] {
        W_IDLE  = 2'd0,
        W_ISSUE = 2'd1,
        W_WAIT  = 2'd2
    } walk_st_t;

    function automatic logic [VAL_W-1:0] step_target(input logic [VAL_W-1:0] base,
                                                     input logic [OFF_W-1:0] off);
        return base + {{(VAL_W-OFF_W){off[OFF_W-1]}}, off};
    endfunction

    function automatic logic [CNT_W-1:0] clamp_steps(input logic [CNT_W-1:0] n);
        return (n > CNT_W'(MAX_STEPS)) ? CNT_W'(MAX_STEPS) : n;
    endfunction
endpackage

// File: rtl/lsp_rep_cache.sv
module lsp_rep_cache
    import lsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  slot_t             wr_data,
    input  logic [PC_W-1:0]   lk_pc,
    output logic              lk_hit,
    output recipe_t           lk_body
);
    slot_t             tbl [SLOTS];
    logic [SLOTS-1:0]  match;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SLOTS; i++) tbl[i] <= '0;
        end else if (wr_en) begin
            tbl[wr_slot] <= wr_data;
        end
    end

    generate
        for (genvar g = 0; g < SLOTS; g++) begin : g_match
            assign match[g] = tbl[g].valid && (tbl[g].tag == lk_pc);
        end
    endgenerate

    // lowest matching slot wins
    always_comb begin
        lk_hit  = |match;
        lk_body = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (match[i]) lk_body = tbl[i].body;
        end
    end
endmodule

// File: rtl/lsp_hist_buf.sv
module lsp_hist_buf
    import lsp_pkg::*;
(
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                load,
    input  logic [VAL_W-1:0]                    root,
    input  logic                                push,
    input  logic [VAL_W-1:0]                    din,
    output logic [HIST_DEPTH-1:0][VAL_W-1:0]    hist
);
    // hist[0] is the newest value; deeper entries are older
    always_ff @(posedge clk) begin
        if (rst) begin
            hist <= '0;
        end else if (load) begin
            hist    <= '0;
            hist[0] <= root;
        end else if (push) begin
            for (int i = HIST_DEPTH - 1; i > 0; i--) hist[i] <= hist[i-1];
            hist[0] <= din;
        end
    end
endmodule

// File: rtl/lsp_walk_ctrl.sv
module lsp_walk_ctrl
    import lsp_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              start,
    input  recipe_t                           start_body,
    input  logic [HIST_DEPTH-1:0][VAL_W-1:0]  hist,
    output logic                              req_valid,
    output logic [VAL_W-1:0]                  req_addr,
    input  logic                              req_ready,
    input  logic                              rsp_valid,
    output logic                              push,
    output logic                              busy
);
    walk_st_t          st_q, st_d;
    recipe_t           body_q;
    logic [STEP_W-1:0] step_q, step_d;
    logic [REP_W-1:0]  rep_q, rep_d;
    step_t             cur;
    logic [VAL_W-1:0]  base;
    logic              last_step, last_rep, null_base;

    always_comb begin
        cur       = body_q.steps[step_q];
        base      = hist[cur.back];
        null_base = (base == '0);
        last_step = ((CNT_W'(step_q) + CNT_W'(1)) == body_q.nsteps);
        last_rep  = ((rep_q + REP_W'(1)) == body_q.reps);
    end

    always_comb begin
        st_d   = st_q;
        step_d = step_q;
        rep_d  = rep_q;
        push   = 1'b0;
        unique case (st_q)
            W_IDLE: begin
                if (start) begin
                    st_d   = W_ISSUE;
                    step_d = '0;
                    rep_d  = '0;
                end
            end
            W_ISSUE: begin
                if (null_base)      st_d = W_IDLE;
                else if (req_ready) st_d = W_WAIT;
            end
            W_WAIT: begin
                if (rsp_valid) begin
                    push = 1'b1;
                    if (!last_step) begin
                        step_d = step_q + STEP_W'(1);
                        st_d   = W_ISSUE;
                    end else begin
                        step_d = '0;
                        if (last_rep) begin
                            st_d = W_IDLE;
                        end else begin
                            rep_d = rep_q + REP_W'(1);
                            st_d  = W_ISSUE;
                        end
                    end
                end
            end
            default: st_d = W_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= W_IDLE;
            step_q <= '0;
            rep_q  <= '0;
            body_q <= '0;
        end else begin
            st_q   <= st_d;
            step_q <= step_d;
            rep_q  <= rep_d;
            if (start && st_q == W_IDLE) body_q <= start_body;
        end
    end

    assign req_valid = (st_q == W_ISSUE) && !null_base;
    assign req_addr  = step_target(base, cur.off);
    assign busy      = (st_q != W_IDLE);
endmodule

// File: rtl/lsp_prefetch_top.sv
module lsp_prefetch_top
    import lsp_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        inst_valid,
    input  logic [SLOT_W-1:0]           inst_slot,
    input  logic [PC_W-1:0]             inst_pc,
    input  logic [CNT_W-1:0]            inst_nsteps,
    input  logic [REP_W-1:0]            inst_reps,
    input  logic [MAX_STEPS*OFF_W-1:0]  inst_offs,
    input  logic [MAX_STEPS*BACK_W-1:0] inst_backs,
    input  logic                        ret_valid,
    input  logic [PC_W-1:0]             ret_pc,
    input  logic [VAL_W-1:0]            ret_value,
    output logic                        req_valid,
    output logic [VAL_W-1:0]            req_addr,
    input  logic                        req_ready,
    input  logic                        rsp_valid,
    input  logic [VAL_W-1:0]            rsp_data,
    output logic                        busy
);
    slot_t                           wr_data;
    logic                            lk_hit;
    recipe_t                         lk_body;
    logic                            start;
    logic                            push;
    logic [HIST_DEPTH-1:0][VAL_W-1:0] hist;

    always_comb begin
        wr_data.valid       = (inst_nsteps != '0) && (inst_reps != '0);
        wr_data.tag         = inst_pc;
        wr_data.body.nsteps = clamp_steps(inst_nsteps);
        wr_data.body.reps   = inst_reps;
    end

    generate
        for (genvar g = 0; g < MAX_STEPS; g++) begin : g_step
            assign wr_data.body.steps[g].off  = inst_offs[g*OFF_W +: OFF_W];
            assign wr_data.body.steps[g].back = inst_backs[g*BACK_W +: BACK_W];
        end
    endgenerate

    assign start = ret_valid && lk_hit && (ret_value != '0) && !busy;

    lsp_rep_cache u_cache (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (inst_valid),
        .wr_slot (inst_slot),
        .wr_data (wr_data),
        .lk_pc   (ret_pc),
        .lk_hit  (lk_hit),
        .lk_body (lk_body)
    );

    lsp_hist_buf u_hist (
        .clk  (clk),
        .rst  (rst),
        .load (start),
        .root (ret_value),
        .push (push),
        .din  (rsp_data),
        .hist (hist)
    );

    lsp_walk_ctrl u_walk (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_body (lk_body),
        .hist       (hist),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_ready  (req_ready),
        .rsp_valid  (rsp_valid),
        .push       (push),
        .busy       (busy)
    );
endmodule

// File: rtl/lsp_prefetch_chk.sv
module lsp_prefetch_chk
    import lsp_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             req_valid,
    input logic             req_ready,
    input logic [VAL_W-1:0] req_addr,
    input logic             rsp_valid
);
    logic in_flight;

    always_ff @(posedge clk) begin
        if (rst)                         in_flight <= 1'b0;
        else if (req_valid && req_ready) in_flight <= 1'b1;
        else if (rsp_valid)              in_flight <= 1'b0;
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!busy && !req_valid));

    assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !req_valid);

    assert_single_outstanding_R5: assert property (@(posedge clk) disable iff (rst)
        in_flight |-> !req_valid);

    assert_req_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));
endmodule

bind lsp_prefetch_top lsp_prefetch_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid)
);

// File: tb/lsp_prefetch_top_test.sv
`timescale 1ns/1ps
module lsp_prefetch_top_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        inst_valid;
    logic [2:0]  inst_slot;
    logic [31:0] inst_pc;
    logic [2:0]  inst_nsteps;
    logic [7:0]  inst_reps;
    logic [63:0] inst_offs;
    logic [7:0]  inst_backs;
    logic        ret_valid;
    logic [31:0] ret_pc;
    logic [31:0] ret_value;
    logic        req_valid;
    logic [31:0] req_addr;
    logic        req_ready;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        busy;

    int checks = 0;
    int fails  = 0;
    logic [31:0] mem [logic [31:0]];
    logic [31:0] exp_q [16];
    int          exp_n;

    always #10 clk = ~clk;

    lsp_prefetch_top uut (
        .clk(clk), .rst(rst),
        .inst_valid(inst_valid), .inst_slot(inst_slot), .inst_pc(inst_pc),
        .inst_nsteps(inst_nsteps), .inst_reps(inst_reps),
        .inst_offs(inst_offs), .inst_backs(inst_backs),
        .ret_valid(ret_valid), .ret_pc(ret_pc), .ret_value(ret_value),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .busy(busy)
    );

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return 32'h11;
    endfunction

    task automatic install(input int slot, input logic [31:0] pc, input int n, input int reps,
                           input logic [15:0] o0, input logic [15:0] o1,
                           input logic [15:0] o2, input logic [15:0] o3,
                           input int d0, input int d1, input int d2, input int d3);
        inst_valid  = 1'b1;
        inst_slot   = 3'(slot);
        inst_pc     = pc;
        inst_nsteps = 3'(n);
        inst_reps   = 8'(reps);
        inst_offs   = {o3, o2, o1, o0};
        inst_backs  = {2'(d3 - 1), 2'(d2 - 1), 2'(d1 - 1), 2'(d0 - 1)};
        @(negedge clk);
        inst_valid  = 1'b0;
    endtask

    task automatic retire(input logic [31:0] pc, input logic [31:0] val);
        ret_valid = 1'b1;
        ret_pc    = pc;
        ret_value = val;
        @(negedge clk);
        ret_valid = 1'b0;
    endtask

    task automatic expect_idle(input string rq);
        chk(!busy && !req_valid, rq, {30'd0, busy, req_valid}, 32'd0);
    endtask

    // serves exp_q[0..exp_n-1]; stalls req_ready for `hold` cycles on the second request
    task automatic serve(input string rq, input int hold);
        logic [31:0] a;
        for (int i = 0; i < exp_n; i++) begin
            for (int k = 0; k < 20 && !req_valid; k++) @(negedge clk);
            chk(req_valid, rq, {31'd0, req_valid}, 32'd1);
            chk(req_addr == exp_q[i], rq, req_addr, exp_q[i]);
            a = req_addr;
            if (hold > 0 && i == 1) begin
                repeat (hold) @(negedge clk);
                chk(req_valid && req_addr == a, "R6 hold", req_addr, a);
            end
            req_ready = 1'b1;
            @(negedge clk);
            req_ready = 1'b0;
            chk(!req_valid, "R5 outstanding", {31'd0, req_valid}, 32'd0);
            @(negedge clk);
            chk(!req_valid, "R5 outstanding", {31'd0, req_valid}, 32'd0);
            rsp_valid = 1'b1;
            rsp_data  = rd(a);
            @(negedge clk);
            rsp_valid = 1'b0;
        end
        chk(!req_valid, rq, {31'd0, req_valid}, 32'd0);
        @(negedge clk);
        expect_idle(rq);
    endtask

    task automatic t_reset;
        chk(!busy && !req_valid, "R1 reset", {30'd0, busy, req_valid}, 32'd0);
        retire(32'h118, 32'h1000);
        expect_idle("R1 empty table");
    endtask

    task automatic t_list;
        mem[32'h1000] = 32'h1;    mem[32'h1004] = 32'hF0;   mem[32'h1008] = 32'h2500;
        mem[32'h2500] = 32'h2;    mem[32'h2504] = 32'hF1;   mem[32'h2508] = 32'h3000;
        mem[32'h3000] = 32'h3;    mem[32'h3004] = 32'hF2;   mem[32'h3008] = 32'h4000;
        install(2, 32'h118, 3, 3, 16'h0, 16'h4, 16'h8, 16'h0, 1, 2, 3, 1);
        retire(32'h118, 32'h1000);
        chk(busy, "R2 hit starts", {31'd0, busy}, 32'd1);
        exp_q[0] = 32'h1000; exp_q[1] = 32'h1004; exp_q[2] = 32'h1008;
        exp_q[3] = 32'h2500; exp_q[4] = 32'h2504; exp_q[5] = 32'h2508;
        exp_q[6] = 32'h3000; exp_q[7] = 32'h3004; exp_q[8] = 32'h3008;
        exp_n = 9;
        serve("R4 list walk", 2);
    endtask

    task automatic t_miss;
        retire(32'h200, 32'h1000);
        expect_idle("R2 miss");
    endtask

    task automatic t_offsets;
        mem[32'h7FFC] = 32'h9000; mem[32'h9010] = 32'hA000; mem[32'h9000] = 32'h9100;
        mem[32'h8020] = 32'hE000; mem[32'hDFFC] = 32'hB000; mem[32'hB010] = 32'hC000;
        mem[32'hB000] = 32'hD000; mem[32'hE020] = 32'h1;
        install(5, 32'h300, 4, 2, 16'hFFFC, 16'h0010, 16'h0000, 16'h0020, 1, 1, 2, 4);
        retire(32'h300, 32'h8000);
        exp_q[0] = 32'h7FFC; exp_q[1] = 32'h9010; exp_q[2] = 32'h9000; exp_q[3] = 32'h8020;
        exp_q[4] = 32'hDFFC; exp_q[5] = 32'hB010; exp_q[6] = 32'hB000; exp_q[7] = 32'hE020;
        exp_n = 8;
        serve("R3 signed offsets and distances", 0);
    endtask

    task automatic t_null;
        mem[32'h5008] = 32'h6000;
        mem[32'h6008] = 32'h0;
        install(0, 32'h400, 1, 10, 16'h8, 16'h0, 16'h0, 16'h0, 1, 1, 1, 1);
        retire(32'h400, 32'h5000);
        exp_q[0] = 32'h5008; exp_q[1] = 32'h6008;
        exp_n = 2;
        serve("R7 null base stops", 0);
        retire(32'h400, 32'h0);
        expect_idle("R7 zero root");
    endtask

    task automatic t_busy_hit;
        retire(32'h118, 32'h1000);
        retire(32'h400, 32'h5000);
        exp_q[0] = 32'h1000; exp_q[1] = 32'h1004; exp_q[2] = 32'h1008;
        exp_q[3] = 32'h2500; exp_q[4] = 32'h2504; exp_q[5] = 32'h2508;
        exp_q[6] = 32'h3000; exp_q[7] = 32'h3004; exp_q[8] = 32'h3008;
        exp_n = 9;
        serve("R8 hit while busy ignored", 0);
    endtask

    task automatic t_replace;
        install(2, 32'h500, 1, 1, 16'h0, 16'h0, 16'h0, 16'h0, 1, 1, 1, 1);
        retire(32'h118, 32'h1000);
        expect_idle("R9 old tag gone");
        retire(32'h500, 32'h7000);
        exp_q[0] = 32'h7000;
        exp_n = 1;
        serve("R9 replaced recipe", 0);
        install(2, 32'h500, 1, 0, 16'h0, 16'h0, 16'h0, 16'h0, 1, 1, 1, 1);
        retire(32'h500, 32'h7000);
        expect_idle("R9 zero reps invalidates");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog R1-R9 scope actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; inst_valid = 1'b0; inst_slot = '0; inst_pc = '0; inst_nsteps = '0;
        inst_reps = '0; inst_offs = '0; inst_backs = '0; ret_valid = 1'b0; ret_pc = '0;
        ret_value = '0; req_ready = 1'b0; rsp_valid = 1'b0; rsp_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_list();
        t_miss();
        t_offsets();
        t_null();
        t_busy_hit();
        t_replace();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule